// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Clear-on-Read

This block gathers single-cycle event pulses from up to `NUM_SRC` internal sources into a bank of status registers. Each register is `REG_W` bits wide. An event is recorded only when its enable bit is set. The enable bit decides whether the event is captured at all; it does not hide a bit that is already latched. Once a status bit is set, it holds until software reads its register.

The block drives an active-low interrupt line. The line is low whenever any status bit is 1. A one-cycle read strobe returns the addressed status register on a registered data output and clears that register in the same cycle. If an event arrives in that same cycle, its bit is still recorded. A one-cycle write strobe loads one enable register. Source `i` maps to register `i / REG_W`, bit `i % REG_W`. The same mapping is used for status and enable.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, `irq_n` is 1 and `rd_data` is 0.
- R2: A pulse on `evt[i]` while enable bit `i` is 1 sets status bit `i` at the next rising clock edge. Source `i` is held in register `i / REG_W`, bit `i % REG_W`.
- R3: A pulse on `evt[i]` while enable bit `i` is 0 is not recorded. Reading the register afterwards returns 0 for that bit, and `irq_n` stays 1.
- R4: `irq_n` is 0 when at least one status bit is 1, and 1 when all status bits are 0.
- R5: A read strobe (`rd_en`=1 for one cycle with `rd_addr`) updates `rd_data` at the next edge with the register's value from before the clear. At that same edge every bit of that register is cleared.
- R6: A read clears only the addressed register. The other registers keep their bits, and `irq_n` stays 0 if any of them is nonzero.
- R7: When an enabled event arrives in the same cycle as a read of its register, its bit is set after the clear. It is absent from that read's data and present in the next read.
- R8: Status bits are sticky. A set bit stays 1 through any number of idle cycles until its register is read.
- R9: A write strobe (`wr_en`=1 with `wr_addr`, `wr_data`) loads enable register `wr_addr` at the next edge. An event in the same cycle as the write is judged against the old enable value.
- R10: Clearing an enable bit does not clear a status bit that is already set. The bit still drives `irq_n` low and is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | NUM_SRC | Single-cycle event pulses, one per source |
| rd_en | input | 1 | Read strobe; clears the addressed status register |
| rd_addr | input | AW | Status register index for a read |
| rd_data | output | REG_W | Pre-clear value of the last register read |
| wr_en | input | 1 | Enable register write strobe |
| wr_addr | input | AW | Enable register index for a write |
| wr_data | input | REG_W | Value to load into the enable register |
| irq_n | output | 1 | Active-low interrupt, low while any status bit is set |

## Verification
The hardest case to reach is a collision: an enabled event lands in the exact cycle that a read clears its register. The bench reaches it by raising the read strobe and the event pulse at the same falling edge, with an older bit already latched in that register. It then expects the first read to return only the older bit and a second read to return only the new one. A similar same-edge overlap of an enable write and an event shows that a new enable takes effect one cycle later.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    function automatic int regs_for(input int n_src, input int reg_w);
        return (n_src + reg_w - 1) / reg_w;
    endfunction

    function automatic int addr_bits(input int n_reg);
        return (n_reg > 1) ? $clog2(n_reg) : 1;
    endfunction

endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int NUM_REG = 4,
    parameter int REG_W   = 8,
    localparam int PAD    = NUM_REG * REG_W,
    localparam int AW     = irq_agg_pkg::addr_bits(NUM_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [PAD-1:0]   en_o
);
    typedef struct packed {
        logic [PAD-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REG; r++) begin
            if (wr_en_i && int'(wr_addr_i) == r) begin
                st_d.en[r*REG_W +: REG_W] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    // Write lands in the addressed enable register one edge later
    assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_addr_i) < NUM_REG) |=>
            en_o[int'($past(wr_addr_i))*REG_W +: REG_W] == $past(wr_data_i));

    assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(en_o));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_REG = 4,
    parameter int REG_W   = 8,
    localparam int PAD    = NUM_REG * REG_W,
    localparam int AW     = irq_agg_pkg::addr_bits(NUM_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAD-1:0]   evt_i,
    input  logic [PAD-1:0]   en_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [PAD-1:0]   stat_o
);
    typedef struct packed {
        logic [PAD-1:0]   stat;
        logic [REG_W-1:0] rdat;
    } st_state_t;

    st_state_t st_d, st_q;
    logic [PAD-1:0] clr_mask;
    logic [PAD-1:0] capture;

    assign capture = evt_i & en_i;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            if (rd_en_i && int'(rd_addr_i) == r) begin
                st_d.rdat = st_q.stat[r*REG_W +: REG_W];
                clr_mask[r*REG_W +: REG_W] = '1;
            end
        end
        // clear first, then record new events so a colliding event survives
        st_d.stat = (st_q.stat & ~clr_mask) | capture;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o    = st_q.stat;
    assign rd_data_o = st_q.rdat;

    assert_enabled_event_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(capture)) == $past(capture)));

    assert_masked_event_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(evt_i & ~en_i & ~stat_o)) == '0));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~clr_mask)) == $past(stat_o & ~clr_mask)));

    assert_read_preclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && int'(rd_addr_i) < NUM_REG) |=>
            rd_data_o == $past(stat_o[int'(rd_addr_i)*REG_W +: REG_W]));

    assert_clear_keeps_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && int'(rd_addr_i) < NUM_REG) |=>
            stat_o[int'($past(rd_addr_i))*REG_W +: REG_W]
                == $past(capture[int'(rd_addr_i)*REG_W +: REG_W]));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int NUM_SRC = 32,
    parameter int REG_W   = 8,
    localparam int NUM_REG = irq_agg_pkg::regs_for(NUM_SRC, REG_W),
    localparam int PAD     = NUM_REG * REG_W,
    localparam int AW      = irq_agg_pkg::addr_bits(NUM_REG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic               irq_n
);
    logic [PAD-1:0] evt_pad;
    logic [PAD-1:0] en_vec;
    logic [PAD-1:0] stat_vec;

    generate
        if (PAD > NUM_SRC) begin : g_pad
            assign evt_pad = {{(PAD-NUM_SRC){1'b0}}, evt};
        end else begin : g_nopad
            assign evt_pad = evt;
        end
    endgenerate

    irq_enable_bank #(.NUM_REG(NUM_REG), .REG_W(REG_W)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .en_o      (en_vec)
    );

    irq_status_bank #(.NUM_REG(NUM_REG), .REG_W(REG_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_pad),
        .en_i      (en_vec),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .stat_o    (stat_vec)
    );

    assign irq_n = ~(|stat_vec);

    // An enabled event always pulls the line low on the following cycle
    assert_irq_follows_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pad & en_vec)) |=> !irq_n);

    // A line released by a read means nothing else was pending or arriving
    assert_irq_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !rd_en) |=> !irq_n);
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    localparam int NUM_SRC = 32;
    localparam int REG_W   = 8;
    localparam int AW      = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] evt = '0;
    logic               rd_en = 1'b0;
    logic [AW-1:0]      rd_addr = '0;
    logic [REG_W-1:0]   rd_data;
    logic               wr_en = 1'b0;
    logic [AW-1:0]      wr_addr = '0;
    logic [REG_W-1:0]   wr_data = '0;
    logic               irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_aggregator #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) dut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_n(irq_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_enable(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] v);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [7:0] exp);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {24'b0, rd_data}, {24'b0, exp});
    endtask

    task automatic t_reset();
        chk("R1 irq_n", {31'b0, irq_n}, 32'd1);
        chk("R1 rd_data", {24'b0, rd_data}, 32'd0);
        for (int r = 0; r < 4; r++) rd_check("R1 status", r, 8'h00);
    endtask

    task automatic t_masked();
        pulse(32'hFFFF_FFFF);
        chk("R3 irq_n", {31'b0, irq_n}, 32'd1);
        for (int r = 0; r < 4; r++) rd_check("R3 status", r, 8'h00);
    endtask

    task automatic t_latch_sticky();
        wr_enable(1, 8'hA5);
        pulse(32'h0000_FF00);
        chk("R4 irq low", {31'b0, irq_n}, 32'd0);
        idle(6);
        chk("R8 sticky irq", {31'b0, irq_n}, 32'd0);
        rd_check("R2 R5 read", 1, 8'hA5);
        chk("R4 irq released", {31'b0, irq_n}, 32'd1);
        rd_check("R5 cleared", 1, 8'h00);
        wr_enable(1, 8'h00);
    endtask

    task automatic t_partial_clear();
        wr_enable(0, 8'hFF);
        wr_enable(3, 8'hFF);
        pulse(32'h8000_0004);
        rd_check("R6 reg0", 0, 8'h04);
        chk("R6 irq held", {31'b0, irq_n}, 32'd0);
        rd_check("R6 reg3", 3, 8'h80);
        chk("R6 irq release", {31'b0, irq_n}, 32'd1);
    endtask

    task automatic t_collision();
        pulse(32'h0000_0002);
        evt = 32'h0000_0008; rd_en = 1'b1; rd_addr = 2'd0;
        @(negedge clk);
        evt = '0; rd_en = 1'b0;
        chk("R7 first read", {24'b0, rd_data}, 32'h02);
        chk("R7 irq", {31'b0, irq_n}, 32'd0);
        rd_check("R7 second read", 0, 8'h08);
    endtask

    task automatic t_disable_after_latch();
        pulse(32'h0000_0001);
        wr_enable(0, 8'h00);
        chk("R10 irq", {31'b0, irq_n}, 32'd0);
        rd_check("R10 read", 0, 8'h01);
        pulse(32'h0000_0001);
        rd_check("R3 after disable", 0, 8'h00);
    endtask

    task automatic t_write_timing();
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'hFF; evt = 32'h0001_0000;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        chk("R9 old enable", {31'b0, irq_n}, 32'd1);
        pulse(32'h0002_0000);
        rd_check("R9 new enable", 2, 8'h02);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_masked();
        t_latch_sticky();
        t_partial_clear();
        t_collision();
        t_disable_after_latch();
        t_write_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule